// File: doc/BRIEF.md
# Mode-Steered GPIO Port Controller

This block controls one general-purpose I/O port of up to eight pins. Every pin has its own bits in a set of per-pin configuration registers: output value, direction, input level select, pull-up enable and Schmitt enable. A wake-up variant adds an edge-select register, a wake-enable register and a set of pending flags. Output values have a dedicated write strobe. All the other configuration registers share a single configuration write strobe. A small mode register decides which configuration register that strobe reaches.

The block drives the pad output value and output enable. It presents the level, pull and Schmitt controls as digital outputs to the pad cell. It returns the pad inputs through a two-flop synchroniser, and it raises an interrupt request when an enabled pin shows its selected edge. The configuration registers reset to all ones, so every pin starts as a tri-stated input with its pull-up off. A parameter can trim the port to its lower pins. The cells of unused pins stay at one and never raise a flag.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every configuration register of every implemented pin reads as one. This gives pad_out = FF, pad_oe = 00, pad_ttl_sel = FF, pad_pull_n = FF and pad_schmitt_n = FF. The pending flags are 0, irq is 0 and the mode register holds 15, so cfg_rdata reads 00.
- R2: A data_wr pulse loads wdata into the output-value register, whatever the mode. pad_out shows the new value after the next clock edge.
- R3: cfg_wr with mode 0 loads the direction register. A direction bit of 0 drives pad_oe[n] = 1, and a direction bit of 1 tri-states pin n. Bit n of every register belongs to pin n, and bit 0 is the lowest pin.
- R4: cfg_wr with mode 1 loads the level-select register (pad_ttl_sel). Mode 2 loads the active-low pull-up register (pad_pull_n). Mode 3 loads the active-low Schmitt register (pad_schmitt_n).
- R5: cfg_wr with any mode value from 7 to 15 changes nothing. No pad control moves, and no register read through cfg_rdata changes.
- R6: cfg_rdata returns the register that the mode selects: 0 direction, 1 level, 2 pull, 3 Schmitt, 4 edge select, 5 wake enable, 6 pending flags. Modes 7 to 15 return 00.
- R7: port_rdata is pad_in passed through two flops. A pad value applied before clock edge k shows on port_rdata after edge k+1, and not after edge k.
- R8: Mode 4 loads the edge-select register, where 1 selects the falling edge and 0 the rising edge. Mode 5 loads the active-low wake-enable register. A pending bit sets on the selected edge of an enabled pin, and it becomes visible three clock edges after the pad changes. Disabled pins and the other edge direction leave the flag clear.
- R9: irq is high exactly when at least one pending bit is set.
- R10: cfg_wr with mode 6 clears each pending bit whose wdata bit is 1. A new edge on the same clock edge as the clear leaves that bit set.
- R11: If mode_wr and cfg_wr occur in the same cycle, the configuration write follows the mode value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr | input | 1 | Load mode_wdata into the mode register |
| mode_wdata | input | 4 | New mode value |
| data_wr | input | 1 | Load wdata into the output-value register |
| cfg_wr | input | 1 | Write wdata to the register picked by the mode |
| wdata | input | 8 | Write data, bit n for pin n |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable, 1 drives |
| pad_ttl_sel | output | 8 | Input level select per pin |
| pad_pull_n | output | 8 | Pull-up enable, active low |
| pad_schmitt_n | output | 8 | Schmitt enable, active low |
| port_rdata | output | 8 | Synchronised pad input levels |
| cfg_rdata | output | 8 | Read-back of the mode-selected register |
| irq | output | 1 | Wake-up interrupt request |

## Verification
Register writes and mode changes take effect on the clock edge that samples the strobe. They are checked half a cycle after that edge. Pad input levels are checked twice: once after the first edge, when the old value must still show, and again after the second edge, when the new value must show. Pending flags and irq are checked after the second edge, when they must still be clear, and after the third edge, when they must be set. One case lines a clear up with the third edge on purpose to show that the new edge wins. Each expectation goes into the scoreboard queue in the cycle that it is due, and the monitor compares it on the following falling clock edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] SEL_DIR  = 4'd0;
  localparam logic [MODE_W-1:0] SEL_LVL  = 4'd1;
  localparam logic [MODE_W-1:0] SEL_PULL = 4'd2;
  localparam logic [MODE_W-1:0] SEL_SCHM = 4'd3;
  localparam logic [MODE_W-1:0] SEL_EDGE = 4'd4;
  localparam logic [MODE_W-1:0] SEL_WEN  = 4'd5;
  localparam logic [MODE_W-1:0] SEL_PEND = 4'd6;
  localparam logic [MODE_W-1:0] SEL_RST  = 4'd15;

  // storage slots inside the configuration bank
  localparam int SLOT_DATA = 0;
  localparam int SLOT_DIR  = 1;
  localparam int SLOT_LVL  = 2;
  localparam int SLOT_PULL = 3;
  localparam int SLOT_SCHM = 4;
  localparam int SLOT_EDGE = 5;
  localparam int SLOT_WEN  = 6;
  localparam int NSLOT     = 7;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ACTIVE_PINS = 8,
  parameter bit HAS_SCHMITT = 1'b1,
  parameter bit HAS_WAKE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   lvl_q,
  output logic [PINS-1:0]   pull_q,
  output logic [PINS-1:0]   schm_q,
  output logic [PINS-1:0]   edge_q,
  output logic [PINS-1:0]   wen_q,
  output logic [PINS-1:0]   clr_mask
);
  localparam logic [PINS-1:0] IMPL = {PINS{1'b1}} >> (PINS - ACTIVE_PINS);
  localparam logic [NSLOT-1:0] PRESENT =
    {HAS_WAKE, HAS_WAKE, HAS_SCHMITT, 1'b1, 1'b1, 1'b1, 1'b1};

  logic [NSLOT-1:0]           slot_we;
  logic [NSLOT-1:0][PINS-1:0] slot_d;
  logic [NSLOT-1:0][PINS-1:0] slot_q;
  logic [PINS-1:0]            wr_val;

  // write steering from the mode register
  always_comb begin
    slot_we            = '0;
    slot_we[SLOT_DATA] = data_wr;
    slot_we[SLOT_DIR]  = cfg_wr && (mode_q == SEL_DIR);
    slot_we[SLOT_LVL]  = cfg_wr && (mode_q == SEL_LVL);
    slot_we[SLOT_PULL] = cfg_wr && (mode_q == SEL_PULL);
    slot_we[SLOT_SCHM] = cfg_wr && (mode_q == SEL_SCHM);
    slot_we[SLOT_EDGE] = cfg_wr && (mode_q == SEL_EDGE);
    slot_we[SLOT_WEN]  = cfg_wr && (mode_q == SEL_WEN);
    wr_val             = (wdata & IMPL) | ~IMPL;
    clr_mask           = (cfg_wr && (mode_q == SEL_PEND)) ? (wdata & IMPL) : '0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (PRESENT[s]) begin : g_live
      always_comb begin
        slot_d[s] = slot_q[s];
        if (slot_we[s]) slot_d[s] = wr_val;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q[s] <= '1;
        else        slot_q[s] <= slot_d[s];
      end
    end else begin : g_tied
      assign slot_d[s] = '1;
      assign slot_q[s] = '1;
    end
  end

  assign data_q = slot_q[SLOT_DATA];
  assign dir_q  = slot_q[SLOT_DIR];
  assign lvl_q  = slot_q[SLOT_LVL];
  assign pull_q = slot_q[SLOT_PULL];
  assign schm_q = slot_q[SLOT_SCHM];
  assign edge_q = slot_q[SLOT_EDGE];
  assign wen_q  = slot_q[SLOT_WEN];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] sync_q,
  output logic [PINS-1:0] prev_q
);
  logic [PINS-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int PINS        = 8,
  parameter int ACTIVE_PINS = 8,
  parameter bit HAS_WAKE    = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] sync_q,
  input  logic [PINS-1:0] prev_q,
  input  logic [PINS-1:0] edge_q,
  input  logic [PINS-1:0] wen_q,
  input  logic [PINS-1:0] clr_mask,
  output logic [PINS-1:0] pend_q
);
  localparam logic [PINS-1:0] IMPL = {PINS{1'b1}} >> (PINS - ACTIVE_PINS);

  if (HAS_WAKE) begin : g_wake
    logic [PINS-1:0] rise, fall, hit, pend_d;

    always_comb begin
      rise   = sync_q & ~prev_q;
      fall   = ~sync_q & prev_q;
      hit    = ((edge_q & fall) | (~edge_q & rise)) & ~wen_q & IMPL;
      pend_d = (pend_q & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
    end
  end else begin : g_nowake
    logic unused;
    assign unused = ^{sync_q, prev_q, edge_q, wen_q, clr_mask, clk, rst_n};
    assign pend_q = '0;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ACTIVE_PINS = 8,
  parameter bit HAS_SCHMITT = 1'b1,
  parameter bit HAS_WAKE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              data_wr,
  input  logic              cfg_wr,
  input  logic [PINS-1:0]   wdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_ttl_sel,
  output logic [PINS-1:0]   pad_pull_n,
  output logic [PINS-1:0]   pad_schmitt_n,
  output logic [PINS-1:0]   port_rdata,
  output logic [PINS-1:0]   cfg_rdata,
  output logic              irq
);
  localparam logic [PINS-1:0] IMPL = {PINS{1'b1}} >> (PINS - ACTIVE_PINS);

  logic              rst_n_sync;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [PINS-1:0]   data_q, dir_q, lvl_q, pull_q, schm_q, edge_q, wen_q;
  logic [PINS-1:0]   clr_mask, sync_q, prev_q, pend_q;

  gpio_rst_sync i_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_sync)
  );

  // mode register: next state, then storage
  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) mode_q <= SEL_RST;
    else             mode_q <= mode_d;
  end

  gpio_cfg_bank #(
    .PINS(PINS), .ACTIVE_PINS(ACTIVE_PINS),
    .HAS_SCHMITT(HAS_SCHMITT), .HAS_WAKE(HAS_WAKE)
  ) i_bank (
    .clk(clk), .rst_n(rst_n_sync), .data_wr(data_wr), .cfg_wr(cfg_wr),
    .mode_q(mode_q), .wdata(wdata),
    .data_q(data_q), .dir_q(dir_q), .lvl_q(lvl_q), .pull_q(pull_q),
    .schm_q(schm_q), .edge_q(edge_q), .wen_q(wen_q), .clr_mask(clr_mask)
  );

  gpio_in_sync #(.PINS(PINS)) i_sync (
    .clk(clk), .rst_n(rst_n_sync), .pad_in(pad_in),
    .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_wake #(
    .PINS(PINS), .ACTIVE_PINS(ACTIVE_PINS), .HAS_WAKE(HAS_WAKE)
  ) i_wake (
    .clk(clk), .rst_n(rst_n_sync), .sync_q(sync_q), .prev_q(prev_q),
    .edge_q(edge_q), .wen_q(wen_q), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  // read-back multiplexer
  always_comb begin
    case (mode_q)
      SEL_DIR:  cfg_rdata = dir_q;
      SEL_LVL:  cfg_rdata = lvl_q;
      SEL_PULL: cfg_rdata = pull_q;
      SEL_SCHM: cfg_rdata = schm_q;
      SEL_EDGE: cfg_rdata = edge_q;
      SEL_WEN:  cfg_rdata = wen_q;
      SEL_PEND: cfg_rdata = pend_q;
      default:  cfg_rdata = '0;
    endcase
  end

  assign pad_out       = data_q;
  assign pad_oe        = ~dir_q & IMPL;
  assign pad_ttl_sel   = lvl_q;
  assign pad_pull_n    = pull_q;
  assign pad_schmitt_n = schm_q;
  assign port_rdata    = sync_q & IMPL;
  assign irq           = |pend_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ACTIVE_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_q,
  input logic              data_wr,
  input logic              cfg_wr,
  input logic [PINS-1:0]   wdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_ttl_sel,
  input logic [PINS-1:0]   pad_pull_n,
  input logic [PINS-1:0]   pad_schmitt_n,
  input logic [PINS-1:0]   port_rdata,
  input logic [PINS-1:0]   cfg_rdata,
  input logic              irq
);
  localparam logic [PINS-1:0] IMPL = {PINS{1'b1}} >> (PINS - ACTIVE_PINS);

  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= 2'd0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((pad_out & IMPL) == ($past(wdata) & IMPL)));

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode_q == SEL_DIR) |=> (pad_oe == (~$past(wdata) & IMPL)));

  // R4
  pull_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode_q == SEL_PULL) |=> ((pad_pull_n & IMPL) == ($past(wdata) & IMPL)));

  // R5
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode_q > SEL_PEND) |=>
      ($stable(pad_oe) && $stable(pad_ttl_sel) && $stable(pad_pull_n) && $stable(pad_schmitt_n)));

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) |-> (port_rdata == ($past(pad_in, 2) & IMPL)));

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SEL_PEND) |-> (irq == (cfg_rdata != '0)));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.PINS(PINS), .ACTIVE_PINS(ACTIVE_PINS)) i_chk (
  .clk(clk), .rst_n(rst_n_sync), .mode_q(mode_q), .data_wr(data_wr),
  .cfg_wr(cfg_wr), .wdata(wdata), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_ttl_sel(pad_ttl_sel), .pad_pull_n(pad_pull_n),
  .pad_schmitt_n(pad_schmitt_n), .port_rdata(port_rdata),
  .cfg_rdata(cfg_rdata), .irq(irq)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, mode_wr, data_wr, cfg_wr;
  logic [3:0] mode_wdata;
  logic [7:0] wdata, pad_in;
  logic [7:0] pad_out, pad_oe, pad_ttl_sel, pad_pull_n, pad_schmitt_n;
  logic [7:0] port_rdata, cfg_rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .data_wr(data_wr), .cfg_wr(cfg_wr), .wdata(wdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ttl_sel(pad_ttl_sel),
    .pad_pull_n(pad_pull_n), .pad_schmitt_n(pad_schmitt_n),
    .port_rdata(port_rdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  // sel: 0 pad_out 1 pad_oe 2 ttl 3 pull 4 schmitt 5 cfg_rdata 6 port_rdata 7 irq
  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return pad_out;
      1: return pad_oe;
      2: return pad_ttl_sel;
      3: return pad_pull_n;
      4: return pad_schmitt_n;
      5: return cfg_rdata;
      6: return port_rdata;
      default: return {7'd0, irq};
    endcase
  endfunction

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = sb.pop_front();
      got = observe(it.sel);
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_mode(logic [3:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    cyc();
    mode_wr = 1'b0;
  endtask

  task automatic wr_cfg(logic [7:0] v);
    cfg_wr = 1'b1; wdata = v;
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] v);
    data_wr = 1'b1; wdata = v;
    cyc();
    data_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; data_wr = 1'b0; cfg_wr = 1'b0;
    mode_wdata = 4'd0; wdata = 8'h00; pad_in = 8'hA5;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    expect_val("R1", 0, 8'hFF);
    expect_val("R1", 1, 8'h00);
    expect_val("R1", 2, 8'hFF);
    expect_val("R1", 3, 8'hFF);
    expect_val("R1", 4, 8'hFF);
    expect_val("R1", 5, 8'h00);
    expect_val("R1", 7, 8'h00);
    expect_val("R7", 6, 8'hA5);

    // R5 reset mode 15 ignores configuration writes
    wr_cfg(8'h00);
    expect_val("R5", 1, 8'h00);
    expect_val("R5", 3, 8'hFF);

    // R4 / R6 level, pull, Schmitt
    wr_mode(4'd1);
    expect_val("R6", 5, 8'hFF);
    wr_cfg(8'h3C);
    expect_val("R4", 2, 8'h3C);
    expect_val("R6", 5, 8'h3C);
    wr_mode(4'd2);
    wr_cfg(8'h0F);
    expect_val("R4", 3, 8'h0F);
    wr_mode(4'd3);
    wr_cfg(8'h81);
    expect_val("R4", 4, 8'h81);
    expect_val("R6", 5, 8'h81);

    // R2 output value, R3 direction and pin order
    wr_data(8'h5A);
    expect_val("R2", 0, 8'h5A);
    expect_val("R4", 4, 8'h81);
    wr_mode(4'd0);
    wr_cfg(8'hF0);
    expect_val("R3", 1, 8'h0F);
    expect_val("R6", 5, 8'hF0);
    expect_val("R2", 0, 8'h5A);

    // R5 out-of-range modes
    wr_mode(4'd7);
    wr_cfg(8'h00);
    expect_val("R5", 1, 8'h0F);
    expect_val("R5", 2, 8'h3C);
    expect_val("R5", 3, 8'h0F);
    expect_val("R6", 5, 8'h00);
    wr_mode(4'd12);
    wr_cfg(8'h55);
    expect_val("R5", 4, 8'h81);
    expect_val("R5", 1, 8'h0F);

    // R11 simultaneous mode and configuration write
    mode_wr = 1'b1; mode_wdata = 4'd0; cfg_wr = 1'b1; wdata = 8'h00;
    cyc();
    mode_wr = 1'b0; cfg_wr = 1'b0;
    expect_val("R11", 1, 8'h0F);
    expect_val("R11", 5, 8'hF0);

    // R7 synchroniser latency
    pad_in = 8'h3C;
    cyc();
    expect_val("R7", 6, 8'hA5);
    cyc();
    expect_val("R7", 6, 8'h3C);
    repeat (2) cyc();

    // R8 edge select and enable
    wr_mode(4'd4);
    wr_cfg(8'h0F);
    expect_val("R8", 5, 8'h0F);
    wr_mode(4'd5);
    wr_cfg(8'h00);
    wr_mode(4'd6);
    expect_val("R8", 5, 8'h00);
    pad_in = 8'hC3;
    cyc();
    cyc();
    expect_val("R8", 7, 8'h00);
    cyc();
    expect_val("R8", 5, 8'hCC);
    expect_val("R9", 7, 8'h01);

    // R10 partial and full clear
    wr_cfg(8'h04);
    expect_val("R10", 5, 8'hC8);
    expect_val("R9", 7, 8'h01);
    wr_cfg(8'hFF);
    expect_val("R10", 5, 8'h00);
    expect_val("R9", 7, 8'h00);

    // R8 only pin 0 enabled
    wr_mode(4'd5);
    wr_cfg(8'hFE);
    wr_mode(4'd6);
    pad_in = 8'h02;
    repeat (3) cyc();
    expect_val("R8", 5, 8'h01);
    pad_in = 8'h03;
    repeat (3) cyc();
    expect_val("R8", 5, 8'h01);
    wr_cfg(8'hFF);
    expect_val("R10", 5, 8'h00);

    // R10 new edge wins over a clear on the same edge
    pad_in = 8'h02;
    cyc();
    cyc();
    cfg_wr = 1'b1; wdata = 8'hFF;
    cyc();
    cfg_wr = 1'b0;
    expect_val("R10", 5, 8'h01);
    expect_val("R9", 7, 8'h01);
    cyc();

    done = 1'b1;
    finish_run();
  end
endmodule